// File: doc/BRIEF.md
# Serial Flash One-Time-Programmable Region Reader

This block is the slave-side front end of a serial flash device for one command: reading a small one-time-programmable region. While chip select is low, it takes an 8-bit command and a 24-bit address from the serial data input, skips one dummy byte, and then shifts stored bytes out on the serial data output. Bytes leave most significant bit first and keep coming until chip select rises.

The region is a 65-byte register array inside the block. A side port loads it for test. The serial clock, chip select and data input are brought into a fast system clock domain through two-flop synchronizers, and their edges are found there. If a write cycle is running when the command byte completes, the request is refused and the block stays silent.

Top module: `otp_spi_reader`

## Requirements
- R1: While reset is asserted, and from a few system clocks after chip select goes high, the output enable `miso_oe` is 0 (data line in high impedance).
- R2: The command byte and then a 24-bit address are sampled on rising serial-clock edges, most significant bit first. The read command is 0x4B. `miso_oe` stays 0 through the command, address and dummy bytes.
- R3: Only address bits 6..0 select the starting byte. Address bits 23..7 have no effect on the returned data.
- R4: Exactly one dummy byte (8 rising edges) follows the address. The first data bit is driven on the falling serial-clock edge that follows the 40th rising edge.
- R5: Data bytes go out most significant bit first, starting at the selected index and advancing by one per byte.
- R6: The index saturates at 64. Reading past byte 64 repeats byte 64, and a starting index of 65..127 returns byte 64.
- R7: Any command byte other than 0x4B produces no output for the rest of that selection.
- R8: If `busy_i` is 1 when the eighth command bit is sampled, the read is refused and `miso_oe` stays 0 for the rest of that selection.
- R9: Raising chip select at any point aborts the sequence and disables the output. The next selection starts again from the command byte.
- R10: With `preload_we` high, `preload_data` is written to the byte at `preload_idx`. Indices 65..127 write nothing.
- R11: The data output changes only in response to a detected falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock (mode 0, idles low) |
| cs_n_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| busy_i | input | 1 | High while a write, program or erase cycle is in progress |
| preload_we | input | 1 | Test write strobe for the region |
| preload_idx | input | 7 | Byte index for the test write |
| preload_data | input | 8 | Byte value for the test write |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable; 0 means the data line is high impedance |

## Verification
The bench uses the default parameters: a 65-byte region, a 24-bit address, opcode 0x4B and two synchronizer stages. It runs the serial clock at one sixteenth of the system rate, so each synchronized edge settles before the bench samples. With the full 7-bit index against 65 entries, the bench can reach the saturation at byte 64, starting indices above 64, and preload writes that fall outside the array.

// File: rtl/otp_spi_pkg.sv
// Shared types for the one-time-programmable region reader.
package otp_spi_pkg;
    // Phase of the serial transaction.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_REJECT
    } phase_t;
endpackage

// File: rtl/otp_spi_sync.sv
// Multi-bit synchronizer: each input bit passes through its own chain of
// flops into the system clock domain.
// Assumes: the bits are independent; each has its own reset value.
module otp_spi_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/otp_spi_store.sv
// Byte array holding the one-time-programmable region.
// One test write port and one combinational read port.
// Assumes: rd_idx < DEPTH (the caller clamps it); erased bytes read 0xFF.
module otp_spi_store #(
    parameter int DEPTH = 65,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    // Erase on reset; test writes land only inside the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en && (wr_idx < IDX_W'(DEPTH))) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // R10
    preload_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx < IDX_W'(DEPTH))) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/otp_spi_reader.sv
// Serial flash slave front end for the one-time-programmable region read.
// Decodes command, address and dummy byte; then shifts bytes out MSB first
// on falling serial-clock edges until chip select rises.
// Assumes: the system clock is several times faster than the serial clock;
// serial mode 0.
module otp_spi_reader #(
    parameter int         DEPTH     = 65,
    parameter int         ADDR_BITS = 24,
    parameter logic [7:0] OPCODE    = 8'h4B,
    parameter int         STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic       busy_i,
    input  logic       preload_we,
    input  logic [6:0] preload_idx,
    input  logic [7:0] preload_data,
    output logic       miso_o,
    output logic       miso_oe
);
    import otp_spi_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(ADDR_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [2:0] raw_in, syn;
    logic       sclk_s, cs_s, mosi_s, sclk_d, cs_d;
    logic       sclk_rise, sclk_fall, cs_fall;

    assign raw_in = {mosi_i, cs_n_i, sclk_i};

    otp_spi_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (syn)
    );

    assign sclk_s = syn[0];
    assign cs_s   = syn[1];
    assign mosi_s = syn[2];

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~cs_s & cs_d;

    phase_t           phase;
    logic [CNT_W-1:0] bit_cnt;
    logic [6:0]       cmd_sh;
    logic [IDX_W-1:0] addr_lo, rd_idx;
    logic [7:0]       out_sh, rd_data;
    logic [2:0]       out_bit;
    logic             started;
    logic [7:0]       cmd_full;

    assign cmd_full = {cmd_sh, mosi_s};

    otp_spi_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (preload_we),
        .wr_idx (IDX_W'(preload_idx)),
        .wr_data(preload_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    // Transaction sequencer: command, address, dummy, data, or refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            cmd_sh  <= '0;
            addr_lo <= '0;
            rd_idx  <= '0;
            out_sh  <= '0;
            out_bit <= '0;
            started <= 1'b0;
        end else if (cs_s) begin
            phase   <= PH_IDLE;
            started <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (cs_fall) begin
                    phase   <= PH_CMD;
                    bit_cnt <= '0;
                end
                PH_CMD: if (sclk_rise) begin
                    cmd_sh <= cmd_full[6:0];
                    if (bit_cnt == CNT_W'(7)) begin
                        bit_cnt <= '0;
                        phase   <= (cmd_full == OPCODE && !busy_i) ? PH_ADDR : PH_REJECT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_ADDR: if (sclk_rise) begin
                    addr_lo <= {addr_lo[IDX_W-2:0], mosi_s};
                    if (bit_cnt == CNT_W'(ADDR_BITS - 1)) begin
                        bit_cnt <= '0;
                        phase   <= PH_DUMMY;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DUMMY: if (sclk_rise) begin
                    if (bit_cnt == CNT_W'(7)) begin
                        phase   <= PH_DATA;
                        out_bit <= '0;
                        rd_idx  <= (addr_lo > LAST_IDX) ? LAST_IDX : addr_lo;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DATA: if (sclk_fall) begin
                    started <= 1'b1;
                    out_bit <= out_bit + 1'b1;
                    if (out_bit == 3'd0) begin
                        out_sh <= rd_data;
                        if (rd_idx != LAST_IDX) rd_idx <= rd_idx + 1'b1;
                    end else begin
                        out_sh <= {out_sh[6:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign miso_o  = out_sh[7];
    assign miso_oe = (phase == PH_DATA) && started;

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);
    // R11
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_o) |-> $past(sclk_fall));
    // R4
    enable_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(sclk_fall));
    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && phase == PH_CMD && sclk_rise && bit_cnt == CNT_W'(7) && busy_i)
        |=> (phase == PH_REJECT));
    // R6
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx <= LAST_IDX);
endmodule

// File: tb/otp_spi_reader_bench.sv
`timescale 1ns/1ps
module otp_spi_reader_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
    logic pre_we = 1'b0;
    logic [6:0] pre_idx = '0;
    logic [7:0] pre_data = '0;
    logic miso, oe;

    int checks = 0, fails = 0;
    int ref_mem [65];
    localparam int HALF = 8;

    always #2 clk = ~clk;

    otp_spi_reader u_otp_spi_reader (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .busy_i(busy), .preload_we(pre_we), .preload_idx(pre_idx),
        .preload_data(pre_data), .miso_o(miso), .miso_oe(oe)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(int idx, int val);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = 7'(idx); pre_data = 8'(val);
        @(negedge clk);
        pre_we = 1'b0;
        if (idx < 65) ref_mem[idx] = val;
    endtask

    // One serial bit in; oe observed just before the rising edge.
    task automatic bit_in(bit b, input string req);
        mosi = b;
        clks(HALF);
        check(oe == 1'b0, req, oe, 0);
        sclk = 1'b1;
        clks(HALF);
        sclk = 1'b0;
    endtask

    // Full transfer with a behavioural model of the expected byte stream.
    task automatic xfer(int cmd, int addr, int in_bits, int data_bits,
                        bit expect_out, input string req);
        int q[$];
        int idx;
        logic [39:0] frame;
        frame = {8'(cmd), 24'(addr), 8'h00};
        idx = addr & 127;
        if (idx > 64) idx = 64;
        for (int k = 0; k < 8; k++) begin
            q.push_back(ref_mem[idx]);
            if (idx < 64) idx++;
        end
        @(negedge clk);
        cs_n = 1'b0;
        clks(HALF);
        for (int k = 0; k < in_bits; k++) bit_in(frame[39-k], "R2 quiet before data");
        for (int k = 0; k < data_bits; k++) begin
            int exp_byte;
            clks(HALF);
            exp_byte = q[k/8];
            if (expect_out) begin
                check(oe == 1'b1, {req, " enable"}, oe, 1);
                check(miso == exp_byte[7 - (k % 8)], {req, " data bit"}, miso,
                      exp_byte[7 - (k % 8)]);
            end else begin
                check(oe == 1'b0, {req, " silent"}, oe, 0);
            end
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
        cs_n = 1'b1;
        clks(HALF);
        check(oe == 1'b0, "R9 deselect disables output", oe, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        clks(4);
        check(oe == 1'b0, "R1 output off in reset", oe, 0);
        rst_n = 1'b1;
        clks(4);
        check(oe == 1'b0, "R1 output off after reset", oe, 0);
        for (int i = 0; i < 65; i++) preload(i, (i * 37 + 11) & 255);
        // R10: out-of-range preload must leave byte 64 (and all others) unchanged
        preload(100, 8'h00);
        preload(65, 8'h00);
        // R5, R4: plain read from index 0
        xfer(8'h4B, 0, 40, 32, 1'b1, "R5 sequential read");
        // R3: upper address bits set, index 5
        xfer(8'h4B, 24'hFFFF85, 40, 24, 1'b1, "R3 upper bits ignored");
        // R6: run past the end
        xfer(8'h4B, 62, 40, 40, 1'b1, "R6 saturate at 64");
        // R6: start beyond the end; also confirms R10 on byte 64
        xfer(8'h4B, 24'h00007F, 40, 16, 1'b1, "R6 R10 start clamp");
        // R7: other opcode
        xfer(8'h03, 0, 40, 16, 1'b0, "R7 foreign opcode");
        // R8: busy refuses the read
        busy = 1'b1;
        xfer(8'h4B, 3, 40, 16, 1'b0, "R8 busy refusal");
        busy = 1'b0;
        // R9: abort mid-data, then mid-address, then a clean read
        xfer(8'h4B, 20, 40, 12, 1'b1, "R9 abort in data");
        xfer(8'h4B, 30, 16, 0, 1'b1, "R9 abort in address");
        xfer(8'h4B, 10, 40, 16, 1'b1, "R9 fresh read after abort");
        // R10: a late preload is seen by the next read
        preload(11, 8'hA5);
        xfer(8'h4B, 11, 40, 8, 1'b1, "R10 preload visible");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule